// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps calendar time in eight packed-BCD byte registers. It steps once for each pulse on a 100 Hz tick enable: hundredths of a second, then seconds, minutes, hours, day of week, date of the month, month, and a two-digit year. Each field rolls over into the next. The hours byte holds a format selector. In 12-hour format an AM/PM flag shares the hours byte with the count. The day byte also holds a halt control and a reset-enable control. The date rolls over according to the length of the current month, including leap-year February.

A host loads any register through a single-cycle write port and reads any register through a combinational read port. Each register keeps only its meaningful bits, so unused bit positions always read back as zero. Crystal prescaling, battery handover and any serial access path sit outside this block. The block expects a one-cycle tick enable that is already divided down to 100 Hz.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the registers read, by address 0..7: 00, 00, 00, 00, 31h, 01, 01, 00. The day register therefore starts with halt (bit 5) and reset-enable (bit 4) both set, so the clock does not run.
- R2: Address map: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A write with `wr_en` high stores `wr_data` into register `wr_addr`, and it is readable on the next cycle. A write wins over a tick in the same cycle: the written value appears, and that cycle's tick advances nothing.
- R3: While day register bit 5 is 1, ticks have no effect on any register. When bit 5 is 0, each tick advances the count by one hundredth.
- R4: Hundredths count 00..99, and seconds and minutes count 00..59, all in BCD. Each field wraps to 00 and carries into the next field.
- R5: With hours bit 7 = 0 (24-hour format), bits 5:0 count 00..23. The step from 23 goes to 00 and carries into day of week and date.
- R6: With hours bit 7 = 1 (12-hour format), bits 4:0 count 01..12 and bit 5 is the PM flag. The step from 11 to 12 toggles the flag. The step from 12 goes to 01 with the flag unchanged. Only the step from 11 PM to 12 AM carries into day and date. Bit 7 is kept.
- R7: Day of week (day register bits 2:0) counts 1..7 and wraps from 7 to 1 on a day carry. Bits 5 and 4 keep their values.
- R8: The date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each rollover increments the month. After month 12 the month goes to 01 and the year increments, with 99 wrapping to 00.
- R9: February ends at 29 when the year is divisible by 4 (00 included), and at 28 otherwise.
- R10: Unused bits are stored and read as 0, whatever was written. The kept-bit masks by address are FFh, 7Fh, 7Fh, BFh, 37h, 3Fh, 1Fh, FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz one-cycle advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index to write |
| wr_data | input | 8 | Value to write |
| rd_addr | input | 3 | Register index to read |
| rd_data | output | 8 | Current value of the addressed register |

## Verification
A long continuous run of ticks from 05:58:00.00 to past 06:00:00 compares every field with a count worked out in the bench. This shows that each digit carries in the right place. Hour sweeps cover all 24 values in 24-hour format and all 24 AM/PM positions in 12-hour format, from the last hundredth of each hour. They show which steps toggle PM and which carry into the date. A sweep over every month against nine years around the divisible-by-four boundary and the century wrap loads both the last day and the day before it. This separates the 28, 29, 30 and 31-day rules and the year carry. Writing all ones to each address shows the bit masks, and a write that coincides with a tick shows the load-over-tick priority.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NREG   = 8;
    localparam int AW     = $clog2(NREG);
    localparam int DW     = 8;
    localparam int NTIME  = 3;

    localparam int IDX_HUND  = 0;
    localparam int IDX_SEC   = 1;
    localparam int IDX_MIN   = 2;
    localparam int IDX_HOUR  = 3;
    localparam int IDX_DAY   = 4;
    localparam int IDX_DATE  = 5;
    localparam int IDX_MONTH = 6;
    localparam int IDX_YEAR  = 7;

    localparam int HOUR_FMT_BIT = 7;
    localparam int HOUR_PM_BIT  = 5;
    localparam int DAY_HALT_BIT = 5;
    localparam int DAY_RSTE_BIT = 4;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        byte_t dow;
        byte_t date;
        byte_t month;
        byte_t year;
    } cal_t;

    function automatic byte_t bcd_inc(input byte_t v);
        byte_t r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input byte_t v);
        logic [6:0] t;
        t = 7'({v[7:4], 3'b000}) + 7'({v[7:4], 1'b0}) + 7'(v[3:0]);
        return t;
    endfunction

    function automatic logic year_is_leap(input byte_t yr);
        logic [6:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic byte_t month_last_day(input byte_t mon, input byte_t yr);
        byte_t d;
        case (mon)
            8'h02:                      d = year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

    function automatic byte_t stage_limit(input int g);
        return (g == IDX_HUND) ? 8'h99 : 8'h59;
    endfunction

    function automatic byte_t reg_mask(input logic [AW-1:0] idx);
        byte_t m;
        case (idx)
            3'd0:    m = 8'hFF;
            3'd1:    m = 8'h7F;
            3'd2:    m = 8'h7F;
            3'd3:    m = 8'hBF;
            3'd4:    m = 8'h37;
            3'd5:    m = 8'h3F;
            3'd6:    m = 8'h1F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    function automatic byte_t reg_reset(input logic [AW-1:0] idx);
        byte_t r;
        case (idx)
            3'd4:    r = 8'h31;
            3'd5:    r = 8'h01;
            3'd6:    r = 8'h01;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
#(
    parameter int STAGES = NTIME
) (
    input  logic [STAGES-1:0][DW-1:0] cur,
    output logic [STAGES-1:0][DW-1:0] nxt,
    output logic                      carry_out
);

    logic [STAGES:0] carry;

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic at_limit;
        assign at_limit     = (cur[g] >= stage_limit(g));
        assign carry[g+1]   = carry[g] & at_limit;
        always_comb begin
            if (!carry[g])     nxt[g] = cur[g];
            else if (at_limit) nxt[g] = '0;
            else               nxt[g] = bcd_inc(cur[g]);
        end
    end

    assign carry_out = carry[STAGES];

endmodule

// File: rtl/rtc_hour_counter.sv
module rtc_hour_counter
    import rtc_pkg::*;
(
    input  byte_t cur,
    input  logic  step,
    output byte_t nxt,
    output logic  day_step
);

    logic  fmt12;
    logic  pm;
    byte_t v24;
    byte_t v12;
    byte_t n12;
    logic  pm_n;

    assign fmt12 = cur[HOUR_FMT_BIT];
    assign pm    = cur[HOUR_PM_BIT];
    assign v24   = {2'b00, cur[5:0]};
    assign v12   = {3'b000, cur[4:0]};

    always_comb begin
        n12  = bcd_inc(v12);
        pm_n = pm;
        if (v12 == 8'h11) begin
            n12  = 8'h12;
            pm_n = ~pm;
        end else if (v12 >= 8'h12) begin
            n12  = 8'h01;
        end
    end

    always_comb begin
        nxt      = cur;
        day_step = 1'b0;
        if (step) begin
            if (fmt12) begin
                nxt      = {1'b1, 1'b0, pm_n, n12[4:0]};
                day_step = (v12 == 8'h11) & pm;
            end else if (v24 >= 8'h23) begin
                nxt      = 8'h00;
                day_step = 1'b1;
            end else begin
                nxt      = bcd_inc(v24);
            end
        end
    end

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
    import rtc_pkg::*;
(
    input  cal_t cur,
    input  logic day_step,
    output cal_t nxt
);

    byte_t last_day;
    logic  month_step;
    logic  year_step;
    logic [2:0] dow_n;

    assign last_day   = month_last_day(cur.month, cur.year);
    assign month_step = day_step & (cur.date >= last_day);
    assign year_step  = month_step & (cur.month >= 8'h12);

    always_comb begin
        if (cur.dow[2:0] >= 3'd7 || cur.dow[2:0] == 3'd0) dow_n = 3'd1;
        else                                              dow_n = cur.dow[2:0] + 3'd1;
    end

    always_comb begin
        nxt = cur;
        if (day_step) begin
            nxt.dow  = {cur.dow[7:3], dow_n};
            nxt.date = month_step ? 8'h01 : bcd_inc(cur.date);
        end
        if (month_step) begin
            nxt.month = year_step ? 8'h01 : bcd_inc(cur.month);
        end
        if (year_step) begin
            nxt.year = (cur.year >= 8'h99) ? 8'h00 : bcd_inc(cur.year);
        end
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    byte_t regs     [NREG];
    byte_t next_val [NREG];

    logic [NTIME-1:0][DW-1:0] tc_cur;
    logic [NTIME-1:0][DW-1:0] tc_nxt;
    logic  min_carry;
    logic  day_step;
    byte_t hour_nxt;
    cal_t  cal_cur;
    cal_t  cal_nxt;
    logic  run;

    assign run = tick & ~wr_en & ~regs[IDX_DAY][DAY_HALT_BIT];

    for (genvar g = 0; g < NTIME; g++) begin : g_time_map
        assign tc_cur[g]   = regs[g];
        assign next_val[g] = tc_nxt[g];
    end

    rtc_time_chain #(.STAGES(NTIME)) u_time (
        .cur       (tc_cur),
        .nxt       (tc_nxt),
        .carry_out (min_carry)
    );

    rtc_hour_counter u_hour (
        .cur      (regs[IDX_HOUR]),
        .step     (min_carry),
        .nxt      (hour_nxt),
        .day_step (day_step)
    );

    assign cal_cur = '{dow:   regs[IDX_DAY],
                       date:  regs[IDX_DATE],
                       month: regs[IDX_MONTH],
                       year:  regs[IDX_YEAR]};

    rtc_date_chain u_date (
        .cur      (cal_cur),
        .day_step (day_step),
        .nxt      (cal_nxt)
    );

    assign next_val[IDX_HOUR]  = hour_nxt;
    assign next_val[IDX_DAY]   = cal_nxt.dow;
    assign next_val[IDX_DATE]  = cal_nxt.date;
    assign next_val[IDX_MONTH] = cal_nxt.month;
    assign next_val[IDX_YEAR]  = cal_nxt.year;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                regs[i] <= reg_reset(AW'(i));
            end else if (wr_en && wr_addr == AW'(i)) begin
                regs[i] <= wr_data & reg_mask(AW'(i));
            end else if (run) begin
                regs[i] <= next_val[i] & reg_mask(AW'(i));
            end
        end
    end

    assign rd_data = regs[rd_addr];

    // R2: a write lands, masked, on the next cycle regardless of tick
    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_addr)] == ($past(wr_data) & reg_mask($past(wr_addr))));

    // R3: halt freezes the count
    a_r3_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (regs[IDX_DAY][DAY_HALT_BIT] && !wr_en) |=> ($stable(regs[IDX_HUND]) && $stable(regs[IDX_SEC])));

    // R4: every running tick changes the hundredths
    a_r4_hund_moves: assert property (@(posedge clk) disable iff (rst)
        run |=> regs[IDX_HUND] != $past(regs[IDX_HUND]));

    // R5: 24-hour format stays in range
    a_r5_hour24_range: assert property (@(posedge clk) disable iff (rst)
        (run && !regs[IDX_HOUR][HOUR_FMT_BIT] && regs[IDX_HOUR] <= 8'h23) |=> regs[IDX_HOUR] <= 8'h23);

    // R6: counting keeps the 12-hour selector and never yields zero
    a_r6_hour12_kept: assert property (@(posedge clk) disable iff (rst)
        (run && regs[IDX_HOUR][HOUR_FMT_BIT]) |=> (regs[IDX_HOUR][HOUR_FMT_BIT] && regs[IDX_HOUR][4:0] != 5'd0));

    // R7: day of week stays 1..7 and control bits are kept
    a_r7_dow_range: assert property (@(posedge clk) disable iff (rst)
        (run && regs[IDX_DAY][2:0] != 3'd0) |=> (regs[IDX_DAY][2:0] != 3'd0 && $stable(regs[IDX_DAY][5:4])));

    // R8: the date never counts to zero
    a_r8_date_nonzero: assert property (@(posedge clk) disable iff (rst)
        (run && regs[IDX_DATE] != 8'h00) |=> regs[IDX_DATE] != 8'h00);

    // R10: unused bits read as zero
    a_r10_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~reg_mask(rd_addr)) == 8'h00);

endmodule

// File: tb/rtc_calendar_core_tb.sv
`timescale 1ns/1ps
module rtc_calendar_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_calendar_core u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic end_of_hour;
        wr(3'd2, 8'h59);
        wr(3'd1, 8'h59);
        wr(3'd0, 8'h99);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] rv [8];
        logic [7:0] mk [8];
        rv = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h01, 8'h00};
        mk = '{8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h37, 8'h3F, 8'h1F, 8'hFF};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            check("R1 reset", v, rv[i]);
        end

        // R3 halted out of reset: tick ignored
        pulse();
        rd(3'd0, v); check("R3 halted at reset", v, 8'h00);

        // R10 masks
        for (int i = 0; i < 8; i++) begin
            wr(3'(i), 8'hFF);
            rd(3'(i), v);
            check("R10 mask", v, mk[i]);
        end

        // R2 load over tick
        wr(3'd4, 8'h11);
        wr(3'd0, 8'h10);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h42;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(3'd0, v); check("R2 load priority", v, 8'h42);
        pulse();
        rd(3'd0, v); check("R2 count after load", v, 8'h43);

        // R3 halt
        wr(3'd1, 8'h17);
        wr(3'd4, 8'h31);
        for (int k = 0; k < 5; k++) pulse();
        rd(3'd0, v); check("R3 halt hund", v, 8'h43);
        rd(3'd1, v); check("R3 halt sec", v, 8'h17);
        rd(3'd4, v); check("R3 halt day", v, 8'h31);

        // R4 continuous run through minute and hour carry
        wr(3'd4, 8'h11);
        wr(3'd3, 8'h05);
        wr(3'd2, 8'h58);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        for (int i = 1; i <= 12100; i++) begin
            int n;
            n = 58 * 6000 + i;
            pulse();
            rd(3'd0, v); check("R4 hundredths", v, bcd(n % 100));
            rd(3'd1, v); check("R4 seconds", v, bcd((n / 100) % 60));
            rd(3'd2, v); check("R4 minutes", v, bcd((n / 6000) % 60));
            rd(3'd3, v); check("R4 hour carry", v, bcd(5 + n / 360000));
        end

        // R5 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            wr(3'd4, 8'h11);
            wr(3'd5, 8'h01);
            wr(3'd6, 8'h01);
            wr(3'd3, bcd(h));
            end_of_hour();
            pulse();
            rd(3'd3, v); check("R5 hour24", v, bcd((h + 1) % 24));
            rd(3'd5, v); check("R5 date carry", v, (h == 23) ? 8'h02 : 8'h01);
            rd(3'd4, v); check("R5 day carry", v, (h == 23) ? 8'h12 : 8'h11);
        end

        // R6 12-hour sweep
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                int eh;
                int ep;
                eh = (h == 12) ? 1 : h + 1;
                ep = (h == 11) ? 1 - pm : pm;
                wr(3'd5, 8'h01);
                wr(3'd6, 8'h01);
                wr(3'd3, 8'h80 | 8'(pm << 5) | bcd(h));
                end_of_hour();
                pulse();
                rd(3'd3, v); check("R6 hour12", v, 8'h80 | 8'(ep << 5) | bcd(eh));
                rd(3'd5, v); check("R6 date carry", v, (h == 11 && pm == 1) ? 8'h02 : 8'h01);
            end
        end

        // R7 day-of-week wrap with control bit kept
        for (int d = 1; d <= 7; d++) begin
            logic [7:0] base;
            base = (d % 2 == 1) ? 8'h10 : 8'h00;
            wr(3'd4, base | 8'(d));
            wr(3'd5, 8'h01);
            wr(3'd3, 8'h23);
            end_of_hour();
            pulse();
            rd(3'd4, v); check("R7 day of week", v, base | 8'((d == 7) ? 1 : d + 1));
        end

        // R8 / R9 month lengths and leap years
        wr(3'd4, 8'h11);
        for (int m = 1; m <= 12; m++) begin
            for (int k = 0; k < 9; k++) begin
                int y;
                int dm;
                y  = (k < 5) ? k : 91 + k;
                dm = mdays(m, y);
                for (int last = 0; last < 2; last++) begin
                    int d0;
                    d0 = last ? dm : dm - 1;
                    wr(3'd7, bcd(y));
                    wr(3'd6, bcd(m));
                    wr(3'd5, bcd(d0));
                    wr(3'd3, 8'h23);
                    end_of_hour();
                    pulse();
                    if (last) begin
                        rd(3'd5, v); check(m == 2 ? "R9 feb rollover" : "R8 month end", v, 8'h01);
                        rd(3'd6, v); check("R8 month step", v, bcd(m == 12 ? 1 : m + 1));
                        rd(3'd7, v); check("R8 year step", v, bcd(m == 12 ? (y + 1) % 100 : y));
                    end else begin
                        rd(3'd5, v); check(m == 2 ? "R9 feb no rollover" : "R8 before end", v, bcd(dm));
                        rd(3'd6, v); check("R8 month held", v, bcd(m));
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule